// File: doc/BRIEF.md
# Flash Program Error Status Unit

This block sits beside a flash array controller and screens every program, erase and read request before the array sees it. Each request is checked combinationally against the current control state and protection ranges: the program must be armed, its access size must equal the configured program width, its bytes must stay inside one 128-bit row, and its target must lie outside every write-protected range. Reads are checked against read-protected ranges. A request that passes is handed to the array through a one-cycle start strobe. A request that fails is never started, and the matching error flags are latched instead.

Software sees the result in one 32-bit status word at register offset 0x0C. The word holds a busy flag for the running operation, an end-of-operation flag, a summary operation-error flag and five specific error flags. Software clears flags by writing 1 to them with byte, half-word or word writes. There are no wait states.

Top module: `flash_err_status`

## Requirements
- R1: After a synchronous reset the status word reads 0x0000_0000. The word is returned only when the register address is 0x0C; a read at any other offset returns zero.
- R2: Bits 31:17, 15:9, 3 and 2 of the status word always read as zero.
- R3: A program (req_kind 0) or erase (req_kind 1) that passes every check pulses op_start in the cycle it is presented, and bit 16 (busy) reads 1 from the next cycle on. While busy is 1, op_done clears busy and sets bit 0 (end of operation) on the next clock edge.
- R4: A program while ctl_prog_armed is 0 sets bit 7.
- R5: A program whose req_size differs from ctl_psize sets bit 6. Both use the encoding 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits.
- R6: A program sets bit 5 when address bits [31:4] of its first byte differ from those of its last byte (first address plus 2^req_size minus 1).
- R7: A program or erase whose address lies inside any write-protect range [wp_lo, wp_hi] (inclusive) sets bit 4.
- R8: A read (req_kind 2) whose address lies inside any read-protect range [rp_lo, rp_hi] sets bit 8. A read never sets bit 1, never pulses op_start and never sets busy.
- R9: Any of bits 7..4 raised by a request also sets bit 1. The failing request does not pulse op_start, and busy stays 0.
- R10: Writing 1 clears bits 8, 7..4, 1 and 0. A bit is cleared only when its byte lane (reg_be[0] for bits 7..0, reg_be[1] for bit 8) is enabled. Writing 0 has no effect, and bit 16 cannot be written.
- R11: When hardware sets a flag in the same cycle that software writes 1 to clear it, the flag ends up set.
- R12: A program or erase presented while busy is 1 is ignored. It raises no flag and does not pulse op_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte offset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 4 | Byte enables for writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| req_valid | input | 1 | Flash request present |
| req_kind | input | 2 | 0 program, 1 erase, 2 read, 3 none |
| req_addr | input | 32 | Request byte address |
| req_size | input | 2 | Access size code |
| ctl_prog_armed | input | 1 | Control register set up for programming |
| ctl_psize | input | 2 | Configured program width code |
| wp_lo | input | 2x32 | Write-protect range low bounds |
| wp_hi | input | 2x32 | Write-protect range high bounds |
| rp_lo | input | 2x32 | Read-protect range low bounds |
| rp_hi | input | 2x32 | Read-protect range high bounds |
| op_done | input | 1 | Array reports the running operation has finished |
| op_start | output | 1 | Accepted program or erase is handed to the array |

## Verification
A hardware error set and a software write-1 clear of the same flag can land in one clock cycle. To provoke this, a bench task drives a failing erase into a write-protected range together with a register write of 1 to bit 4, with both strobes active on the same edge. A readback on the next cycle must still show bit 4 and bit 1 set. The same test also confirms that a write of 0, or a write on a disabled byte lane, leaves each flag unchanged.

// File: rtl/flash_err_pkg.sv
package flash_err_pkg;

    typedef enum logic [1:0] {
        KIND_PROG  = 2'd0,
        KIND_ERASE = 2'd1,
        KIND_READ  = 2'd2,
        KIND_NONE  = 2'd3
    } req_kind_e;

    typedef logic [1:0] size_code_t;

    typedef struct packed {
        logic rd;   // read-protect hit
        logic seq;  // program not armed
        logic par;  // size mismatch
        logic row;  // row crossing
        logic wp;   // write-protect hit
    } err_set_t;

    localparam int BIT_EOP   = 0;
    localparam int BIT_OPERR = 1;
    localparam int BIT_WP    = 4;
    localparam int BIT_ROW   = 5;
    localparam int BIT_PAR   = 6;
    localparam int BIT_SEQ   = 7;
    localparam int BIT_RD    = 8;
    localparam int BIT_BUSY  = 16;

    function automatic logic [31:0] last_byte(input logic [31:0] a, input size_code_t s);
        return a + ((32'd1 << s) - 32'd1);
    endfunction

    function automatic logic any_prog_err(input err_set_t e);
        return e.seq | e.par | e.row | e.wp;
    endfunction

endpackage

// File: rtl/flash_region_match.sv
module flash_region_match #(
    parameter int N_RANGE = 2,
    parameter int AW      = 32
) (
    input  logic [N_RANGE-1:0][AW-1:0] lo,
    input  logic [N_RANGE-1:0][AW-1:0] hi,
    input  logic [AW-1:0]              addr,
    output logic                       hit
);
    logic [N_RANGE-1:0] in_rng;

    for (genvar g = 0; g < N_RANGE; g++) begin : g_rng
        assign in_rng[g] = (addr >= lo[g]) && (addr <= hi[g]);
    end

    assign hit = |in_rng;
endmodule

// File: rtl/flash_access_check.sv
module flash_access_check
    import flash_err_pkg::*;
#(
    parameter int ROW_BYTES = 16
) (
    input  logic       valid,
    input  req_kind_e  kind,
    input  logic [31:0] addr,
    input  size_code_t size,
    input  size_code_t psize,
    input  logic       armed,
    input  logic       wp_hit,
    input  logic       rp_hit,
    output err_set_t   err
);
    localparam int ROW_LSB = $clog2(ROW_BYTES);

    logic        is_prog, is_erase, is_read;
    logic [31:0] end_addr;

    assign is_prog  = valid && (kind == KIND_PROG);
    assign is_erase = valid && (kind == KIND_ERASE);
    assign is_read  = valid && (kind == KIND_READ);
    assign end_addr = last_byte(addr, size);

    always_comb begin
        err     = '0;
        err.seq = is_prog && !armed;
        err.par = is_prog && (size != psize);
        err.row = is_prog && (addr[31:ROW_LSB] != end_addr[31:ROW_LSB]);
        err.wp  = (is_prog || is_erase) && wp_hit;
        err.rd  = is_read && rp_hit;
    end

    // R8: reads never produce program-side errors
    always_comb begin
        assert_read_no_prog_err_R8: assert (!(is_read && any_prog_err(err)));
    end
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
    import flash_err_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  err_set_t    hw_set,
    input  logic        start,
    input  logic        done,
    input  logic        wr_en,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    output logic [31:0] word,
    output logic        busy
);
    logic eop_q, operr_q, wp_q, row_q, par_q, seq_q, rd_q, busy_q;
    logic lane0, lane1, finish, op_err;

    assign lane0  = wr_en && wr_be[0];
    assign lane1  = wr_en && wr_be[1];
    assign finish = busy_q && done;
    assign op_err = any_prog_err(hw_set);

    always_ff @(posedge clk) begin
        if (rst) begin
            eop_q <= 1'b0; operr_q <= 1'b0; wp_q <= 1'b0; row_q <= 1'b0;
            par_q <= 1'b0; seq_q <= 1'b0; rd_q <= 1'b0; busy_q <= 1'b0;
        end else begin
            // set has priority over write-one clear
            eop_q   <= finish     | (eop_q   & ~(lane0 & wr_data[BIT_EOP]));
            operr_q <= op_err     | (operr_q & ~(lane0 & wr_data[BIT_OPERR]));
            wp_q    <= hw_set.wp  | (wp_q    & ~(lane0 & wr_data[BIT_WP]));
            row_q   <= hw_set.row | (row_q   & ~(lane0 & wr_data[BIT_ROW]));
            par_q   <= hw_set.par | (par_q   & ~(lane0 & wr_data[BIT_PAR]));
            seq_q   <= hw_set.seq | (seq_q   & ~(lane0 & wr_data[BIT_SEQ]));
            rd_q    <= hw_set.rd  | (rd_q    & ~(lane1 & wr_data[BIT_RD]));
            if (start)       busy_q <= 1'b1;
            else if (finish) busy_q <= 1'b0;
        end
    end

    always_comb begin
        word            = '0;
        word[BIT_EOP]   = eop_q;
        word[BIT_OPERR] = operr_q;
        word[BIT_WP]    = wp_q;
        word[BIT_ROW]   = row_q;
        word[BIT_PAR]   = par_q;
        word[BIT_SEQ]   = seq_q;
        word[BIT_RD]    = rd_q;
        word[BIT_BUSY]  = busy_q;
    end
    assign busy = busy_q;

    logic unused_wdata;
    assign unused_wdata = ^{wr_data[31:9], wr_data[3:2], wr_be[3:2]};

    assert_hw_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
        hw_set.wp |=> wp_q);
    assert_operr_follows_R9: assert property (@(posedge clk) disable iff (rst)
        op_err |=> operr_q);
    assert_eop_on_done_R3: assert property (@(posedge clk) disable iff (rst)
        (busy_q && done && !start) |=> (eop_q && !busy_q));
    assert_w0_no_effect_R10: assert property (@(posedge clk) disable iff (rst)
        (!hw_set.seq && !(lane0 && wr_data[BIT_SEQ])) |=> (seq_q == $past(seq_q)));
endmodule

// File: rtl/flash_err_status.sv
module flash_err_status
    import flash_err_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int STATUS_ADR = 'h0C,
    parameter int N_WP       = 2,
    parameter int N_RP       = 2,
    parameter int ROW_BYTES  = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic                   reg_rd,
    input  logic                   reg_wr,
    input  logic [3:0]             reg_be,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    input  logic                   req_valid,
    input  logic [1:0]             req_kind,
    input  logic [31:0]            req_addr,
    input  logic [1:0]             req_size,
    input  logic                   ctl_prog_armed,
    input  logic [1:0]             ctl_psize,
    input  logic [N_WP-1:0][31:0]  wp_lo,
    input  logic [N_WP-1:0][31:0]  wp_hi,
    input  logic [N_RP-1:0][31:0]  rp_lo,
    input  logic [N_RP-1:0][31:0]  rp_hi,
    input  logic                   op_done,
    output logic                   op_start
);
    req_kind_e   kind;
    logic        reg_hit, is_write, check_valid, wp_hit, rp_hit, busy;
    err_set_t    err;
    logic [31:0] word;

    assign kind        = req_kind_e'(req_kind);
    assign reg_hit     = (reg_addr == ADDR_W'(STATUS_ADR));
    assign is_write    = (kind == KIND_PROG) || (kind == KIND_ERASE);
    assign check_valid = req_valid && !(is_write && busy);

    flash_region_match #(.N_RANGE(N_WP), .AW(32)) u_wp_match (
        .lo(wp_lo), .hi(wp_hi), .addr(req_addr), .hit(wp_hit));

    flash_region_match #(.N_RANGE(N_RP), .AW(32)) u_rp_match (
        .lo(rp_lo), .hi(rp_hi), .addr(req_addr), .hit(rp_hit));

    flash_access_check #(.ROW_BYTES(ROW_BYTES)) u_check (
        .valid(check_valid), .kind(kind), .addr(req_addr), .size(req_size),
        .psize(ctl_psize), .armed(ctl_prog_armed), .wp_hit(wp_hit),
        .rp_hit(rp_hit), .err(err));

    assign op_start = check_valid && is_write && !any_prog_err(err);

    flash_status_reg u_status (
        .clk(clk), .rst(rst), .hw_set(err), .start(op_start), .done(op_done),
        .wr_en(reg_wr && reg_hit), .wr_be(reg_be), .wr_data(reg_wdata),
        .word(word), .busy(busy));

    assign reg_rdata = (reg_rd && reg_hit) ? word : 32'd0;

    assert_start_when_idle_R12: assert property (@(posedge clk) disable iff (rst)
        op_start |-> !busy);
    assert_busy_from_start_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(op_start));
endmodule

// File: tb/flash_err_status_bench.sv
module flash_err_status_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  reg_addr;
    logic        reg_rd, reg_wr;
    logic [3:0]  reg_be;
    logic [31:0] reg_wdata, reg_rdata;
    logic        req_valid;
    logic [1:0]  req_kind, req_size, ctl_psize;
    logic [31:0] req_addr;
    logic        ctl_prog_armed, op_done, op_start;
    logic [1:0][31:0] wp_lo, wp_hi, rp_lo, rp_hi;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    flash_err_status u_flash_err_status (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_size(req_size), .ctl_prog_armed(ctl_prog_armed), .ctl_psize(ctl_psize),
        .wp_lo(wp_lo), .wp_hi(wp_hi), .rp_lo(rp_lo), .rp_hi(rp_hi),
        .op_done(op_done), .op_start(op_start));

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        reg_addr = 8'h0C; reg_wr = 1'b1; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic issue(input logic [1:0] k, input logic [31:0] a, input logic [1:0] s,
                         output logic st);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_size = s;
        #1 st = op_start;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_op();
        @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    task automatic clear_all();
        wr(4'hF, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h0C, v); chk("R1 reset value", v, 32'h0);
        rd(8'h08, v); chk("R1 other offset", v, 32'h0);
    endtask

    task automatic t_good_prog();
        logic [31:0] v; logic st;
        ctl_prog_armed = 1'b1; ctl_psize = 2'd2;
        issue(2'd0, 32'h0800_0000, 2'd2, st);
        chk("R3 start pulse", {31'd0, st}, 32'd1);
        rd(8'h0C, v); chk("R3 busy set", v, 32'h0001_0000);
        // R12: erase into protected range while busy is ignored
        issue(2'd1, 32'h0800_5000, 2'd0, st);
        chk("R12 no start when busy", {31'd0, st}, 32'd0);
        wr(4'hF, 32'hFFFF_FFFF);
        rd(8'h0C, v); chk("R12 no flag / R10 busy not writable", v, 32'h0001_0000);
        finish_op();
        rd(8'h0C, v); chk("R3 done -> eop", v, 32'h0000_0001);
        wr(4'h1, 32'h1);
        rd(8'h0C, v); chk("R10 clear eop", v, 32'h0);
    endtask

    task automatic t_seq();
        logic [31:0] v; logic st;
        ctl_prog_armed = 1'b0; ctl_psize = 2'd2;
        issue(2'd0, 32'h0800_0000, 2'd2, st);
        chk("R9 no start on error", {31'd0, st}, 32'd0);
        rd(8'h0C, v); chk("R4 seq err", v, 32'h0000_0082);
        ctl_prog_armed = 1'b1;
        clear_all();
        issue(2'd0, 32'h0800_0000, 2'd1, st);
        rd(8'h0C, v); chk("R5 size mismatch", v, 32'h0000_0042);
        clear_all();
        ctl_prog_armed = 1'b0;
        issue(2'd0, 32'h0800_0000, 2'd1, st);
        rd(8'h0C, v); chk("R4 R5 combined", v, 32'h0000_00C2);
        ctl_prog_armed = 1'b1;
        clear_all();
        rd(8'h0C, v); chk("R10 clear all", v, 32'h0);
    endtask

    task automatic t_row();
        logic [31:0] v; logic st;
        ctl_psize = 2'd2;
        issue(2'd0, 32'h0800_000E, 2'd2, st);
        rd(8'h0C, v); chk("R6 row cross", v, 32'h0000_0022);
        clear_all();
        ctl_psize = 2'd3;
        issue(2'd0, 32'h0800_0008, 2'd3, st);
        chk("R6 64-bit at row end starts", {31'd0, st}, 32'd1);
        finish_op();
        rd(8'h0C, v); chk("R6 no row err", v, 32'h0000_0001);
        clear_all();
        ctl_psize = 2'd2;
    endtask

    task automatic t_wp();
        logic [31:0] v; logic st;
        issue(2'd1, 32'h0800_5000, 2'd0, st);
        rd(8'h0C, v); chk("R7 erase protected", v, 32'h0000_0012);
        clear_all();
        issue(2'd0, 32'h0800_7FFC, 2'd2, st);
        rd(8'h0C, v); chk("R7 program at range top", v, 32'h0000_0012);
        clear_all();
    endtask

    task automatic t_rd();
        logic [31:0] v; logic st;
        issue(2'd2, 32'h0801_0004, 2'd2, st);
        chk("R8 read no start", {31'd0, st}, 32'd0);
        rd(8'h0C, v); chk("R8 read protect", v, 32'h0000_0100);
        clear_all();
        issue(2'd2, 32'h0802_0000, 2'd2, st);
        rd(8'h0C, v); chk("R8 read outside", v, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] v; logic st;
        issue(2'd2, 32'h0801_0000, 2'd2, st);
        issue(2'd1, 32'h0800_4000, 2'd0, st);
        wr(4'hF, 32'h0);
        rd(8'h0C, v); chk("R10 write zero no effect", v, 32'h0000_0112);
        wr(4'h2, 32'h0000_00FF);
        rd(8'h0C, v); chk("R10 disabled lane keeps bits", v, 32'h0000_0112);
        wr(4'h1, 32'h0000_01FF);
        rd(8'h0C, v); chk("R10 lane0 clears low byte", v, 32'h0000_0100);
        wr(4'h2, 32'h0000_0100);
        rd(8'h0C, v); chk("R10 lane1 clears bit 8 / R2 reserved", v, 32'h0);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd1; req_addr = 32'h0800_6000; req_size = 2'd0;
        reg_addr = 8'h0C; reg_wr = 1'b1; reg_be = 4'h1; reg_wdata = 32'h0000_0012;
        @(negedge clk);
        req_valid = 1'b0; reg_wr = 1'b0;
        rd(8'h0C, v); chk("R11 set beats clear", v, 32'h0000_0012);
        clear_all();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_addr = '0; reg_rd = 1'b0; reg_wr = 1'b0; reg_be = '0;
        reg_wdata = '0; req_valid = 1'b0; req_kind = 2'd3; req_addr = '0;
        req_size = '0; ctl_prog_armed = 1'b1; ctl_psize = 2'd2; op_done = 1'b0;
        wp_lo[0] = 32'h0800_4000; wp_hi[0] = 32'h0800_7FFF;
        wp_lo[1] = 32'hFFFF_FFFF; wp_hi[1] = 32'h0000_0000;
        rp_lo[0] = 32'h0801_0000; rp_hi[0] = 32'h0801_FFFF;
        rp_lo[1] = 32'hFFFF_FFFF; rp_hi[1] = 32'h0000_0000;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_good_prog();
        t_seq();
        t_row();
        t_wp();
        t_rd();
        t_w1c();
        t_priority();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule